// File: doc/BRIEF.md
# Memory User-Interface Command Responder

This block stands in for a DDR-style memory controller behind an on-chip RAM. It lets application logic that drives a controller's user interface run against a model that behaves predictably. A requester issues read and write commands on a command channel. Write data arrives on a separate channel. Read results return on a third channel. The command channel and the write-data channel are independent. A data beat can be delivered any number of cycles before its write command. Each accepted write command consumes the oldest queued beat.

Both ready outputs drop at pseudo-random cycles, driven by a 16-bit LFSR with a parameter seed. Each ready output is a register. The value seen before an edge decides whether that edge accepts a transfer. After reset, both channels stay closed until a calibration-complete flag comes up. This lets requesters exercise their hold-until-accepted logic, their back-to-back issue and their early-data paths.

Top module: `memui_responder`

## Requirements
- R1: A command is taken only on a rising edge where `cmd_en` and `cmd_rdy` are both high. While `cmd_rdy` is low, a held command is not taken and produces no effect.
- R2: Each edge with `cmd_en` and `cmd_rdy` both high is one separate command. Holding `cmd_en` high over consecutive ready edges issues one command per edge.
- R3: Op code 3'b000 is a write and 3'b001 is a read. Any other op code is taken and then ignored. It returns no read data, consumes no write beat and changes no RAM word.
- R4: Write beats are queued in a 16-entry FIFO, with no limit on how long a beat may wait. A beat is taken on an edge where `wd_en` and `wd_rdy` are both high. Write commands pair with queued beats in arrival order.
- R5: `wd_rdy` is low whenever 16 beats are queued.
- R6: A write command taken while no beat is queued is parked. `cmd_rdy` stays low until a beat arrives and the parked write has been performed.
- R7: Bit b of `wd_mask` guards byte b, which is `wd_data[8b+7:8b]`. A mask bit of 0 writes that byte and a mask bit of 1 leaves it unchanged.
- R8: Address bits [2:0] are ignored. Bits [8:3] select one of 64 RAM words, and higher address bits are ignored.
- R9: A read taken at edge E returns the word on `rd_data` after edge E+4. `rd_valid` and `rd_end` are both high for that single cycle, and reads return in command order.
- R10: `calib_done` rises on the 32nd rising edge after reset is released and then stays high. `cmd_rdy` and `wd_rdy` are low whenever `calib_done` is low.
- R11: During reset, `cmd_rdy`, `wd_rdy`, `rd_valid`, `rd_end` and `calib_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_en | input | 1 | Command request |
| cmd_op | input | 3 | Command op code (000 write, 001 read) |
| cmd_addr | input | 28 | Command address, bits [8:3] select the word |
| cmd_rdy | output | 1 | Command may be taken at the next edge |
| wd_data | input | 512 | Write beat data |
| wd_mask | input | 64 | Byte mask, 0 means write the byte |
| wd_end | input | 1 | Last-beat flag (single-beat transfers) |
| wd_en | input | 1 | Write beat request |
| wd_rdy | output | 1 | Write beat may be taken at the next edge |
| rd_data | output | 512 | Returned read word |
| rd_valid | output | 1 | Read word valid |
| rd_end | output | 1 | Last beat of the read return |
| calib_done | output | 1 | Start-up delay complete |

## Verification
Inputs are driven on the falling edge. Each ready output is read there, and that value decides whether the following rising edge takes a transfer. The bench therefore knows the exact accepting edge of every command and every beat without modelling the LFSR. Every read it issues is given a due cycle four rising edges after its accepting edge, and the return monitor samples on the falling edge of that cycle. There it requires `rd_valid`, `rd_end` and the expected word, and it treats a return in any other cycle as a failure. The flag checks have fixed due points: the calibration flag is sampled after the 31st and 32nd edges following reset release, and the stall outputs one falling edge after the transfer that should close them.

// File: rtl/memui_pkg.sv
`timescale 1ns/1ps
package memui_pkg;
  localparam logic [2:0] OP_WRITE = 3'b000;
  localparam logic [2:0] OP_READ  = 3'b001;
endpackage

// File: rtl/mu_stall_gen.sv
`timescale 1ns/1ps
module mu_stall_gen #(
  parameter logic [15:0] SEED = 16'hACE1,
  parameter logic [15:0] TAPS = 16'hB400
) (
  input  logic clk,
  input  logic rst,
  output logic stall_cmd,
  output logic stall_wd
);
  logic [15:0] lfsr_q;

  always_ff @(posedge clk) begin
    if (rst) lfsr_q <= (SEED == 16'h0) ? 16'h1 : SEED;
    else     lfsr_q <= {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? TAPS : 16'h0);
  end

  assign stall_cmd = lfsr_q[0] & lfsr_q[1];
  assign stall_wd  = lfsr_q[4] & lfsr_q[7];
endmodule

// File: rtl/mu_wfifo.sv
`timescale 1ns/1ps
module mu_wfifo #(
  parameter int WIDTH = 576,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign head  = mem[rp];
  assign empty = (count == '0);

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) push |-> (count < CW'(DEPTH))); // R5
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> (count != '0)); // R4
endmodule

// File: rtl/mu_store.sv
`timescale 1ns/1ps
module mu_store #(
  parameter int DATA_W = 512,
  parameter int WORDS  = 64,
  parameter int LAT    = 4,
  localparam int MASK_W = DATA_W / 8,
  localparam int IDX_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [MASK_W-1:0] wmask,
  input  logic              re,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] mem [WORDS];
  logic [IDX_W-1:0]  rq_idx;
  logic [DATA_W-1:0] ram_q;
  logic [LAT:0]      vpipe;
  logic [DATA_W-1:0] dpipe [LAT-1];

  // byte-lane write, mask bit low enables the lane
  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < MASK_W; b++) begin
        if (!wmask[b]) mem[widx][b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end

  // request captured on the accepting edge, RAM read one edge later
  always_ff @(posedge clk) begin
    rq_idx <= ridx;
    ram_q  <= mem[rq_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[LAT-1:0], re};
  end

  for (genvar k = 0; k < LAT - 1; k++) begin : g_dly
    if (k == 0) begin : g_first
      always_ff @(posedge clk) dpipe[0] <= ram_q;
    end else begin : g_next
      always_ff @(posedge clk) dpipe[k] <= dpipe[k-1];
    end
  end

  assign rdata  = dpipe[LAT-2];
  assign rvalid = vpipe[LAT];
endmodule

// File: rtl/memui_responder.sv
`timescale 1ns/1ps
module memui_responder #(
  parameter int          DATA_W     = 512,
  parameter int          ADDR_W     = 28,
  parameter int          MEM_WORDS  = 64,
  parameter int          FIFO_DEPTH = 16,
  parameter int          READ_LAT   = 4,
  parameter int          CAL_CYCLES = 32,
  parameter logic [15:0] LFSR_SEED  = 16'hACE1,
  localparam int MASK_W = DATA_W / 8,
  localparam int IDX_W  = $clog2(MEM_WORDS),
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1),
  localparam int CAL_W  = $clog2(CAL_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_en,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_rdy,
  input  logic [DATA_W-1:0] wd_data,
  input  logic [MASK_W-1:0] wd_mask,
  input  logic              wd_end,
  input  logic              wd_en,
  output logic              wd_rdy,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_end,
  output logic              calib_done
);
  logic [CAL_W-1:0] cal_cnt;
  logic             calib_n;
  logic             stall_c, stall_w;
  logic             cmd_acc, is_wr, is_rd, rd_go;
  logic             wr_now, wr_park, wr_pend, wr_fire, wd_push;
  logic             pend_q, pend_n;
  logic [IDX_W-1:0] pend_idx, cmd_idx, wr_idx;
  logic [MASK_W+DATA_W-1:0] fifo_head;
  logic             fifo_empty;
  logic [CNT_W-1:0] fifo_cnt, cnt_n;
  logic             unused_addr_bits;

  assign unused_addr_bits = ^{wd_end, cmd_addr[2:0], cmd_addr[ADDR_W-1:3+IDX_W]};

  // start-up delay
  always_ff @(posedge clk) begin
    if (rst) begin
      cal_cnt    <= '0;
      calib_done <= 1'b0;
    end else if (!calib_done) begin
      cal_cnt <= cal_cnt + 1'b1;
      if (cal_cnt == CAL_W'(CAL_CYCLES - 1)) calib_done <= 1'b1;
    end
  end
  assign calib_n = calib_done | (cal_cnt == CAL_W'(CAL_CYCLES - 1));

  mu_stall_gen #(.SEED(LFSR_SEED)) u_stall (
    .clk(clk), .rst(rst), .stall_cmd(stall_c), .stall_wd(stall_w)
  );

  // command decode and write pairing
  assign cmd_acc = cmd_en && cmd_rdy;
  assign is_wr   = (cmd_op == memui_pkg::OP_WRITE);
  assign is_rd   = (cmd_op == memui_pkg::OP_READ);
  assign cmd_idx = cmd_addr[3 +: IDX_W];
  assign rd_go   = cmd_acc && is_rd;
  assign wr_now  = cmd_acc && is_wr && !fifo_empty;
  assign wr_park = cmd_acc && is_wr && fifo_empty;
  assign wr_pend = pend_q && !fifo_empty;
  assign wr_fire = wr_now || wr_pend;
  assign wr_idx  = pend_q ? pend_idx : cmd_idx;
  assign pend_n  = wr_park || (pend_q && fifo_empty);
  assign wd_push = wd_en && wd_rdy;
  assign cnt_n   = fifo_cnt + CNT_W'(wd_push) - CNT_W'(wr_fire);

  mu_wfifo #(.WIDTH(MASK_W + DATA_W), .DEPTH(FIFO_DEPTH)) u_wfifo (
    .clk(clk), .rst(rst),
    .push(wd_push), .din({wd_mask, wd_data}),
    .pop(wr_fire), .head(fifo_head),
    .empty(fifo_empty), .count(fifo_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      pend_idx <= '0;
      cmd_rdy  <= 1'b0;
      wd_rdy   <= 1'b0;
    end else begin
      pend_q  <= pend_n;
      if (wr_park) pend_idx <= cmd_idx;
      cmd_rdy <= calib_n && !stall_c && !pend_n;
      wd_rdy  <= calib_n && !stall_w && (cnt_n < CNT_W'(FIFO_DEPTH));
    end
  end

  mu_store #(.DATA_W(DATA_W), .WORDS(MEM_WORDS), .LAT(READ_LAT)) u_store (
    .clk(clk), .rst(rst),
    .we(wr_fire), .widx(wr_idx),
    .wdata(fifo_head[DATA_W-1:0]), .wmask(fifo_head[MASK_W+DATA_W-1:DATA_W]),
    .re(rd_go), .ridx(cmd_idx),
    .rdata(rd_data), .rvalid(rd_valid)
  );
  assign rd_end = rd_valid;

  AST_RDY_WAITS_CAL: assert property (@(posedge clk) disable iff (rst) !calib_done |-> (!cmd_rdy && !wd_rdy)); // R10
  AST_CAL_HOLDS: assert property (@(posedge clk) disable iff (rst) calib_done |=> calib_done); // R10
  AST_PARK_BLOCKS_CMD: assert property (@(posedge clk) disable iff (rst) pend_q |-> !cmd_rdy); // R6
  AST_PARK_WAITS_DATA: assert property (@(posedge clk) disable iff (rst) (pend_q && fifo_empty) |=> pend_q); // R6
endmodule

// File: tb/memui_responder_tb.sv
`timescale 1ns/1ps
module memui_responder_tb;
  localparam int DW = 512;
  localparam int MW = 64;
  localparam int AW = 28;
  localparam int WORDS = 64;

  typedef struct packed {
    logic [2:0]    op;
    logic [5:0]    idx;
    logic [7:0]    seed;
    logic [MW-1:0] mask;
  } vec_t;

  // R3 op codes: 3'b000 write, 3'b001 read; R7 mask bit 1 keeps the byte
  localparam vec_t TBL [8] = '{
    '{3'b000, 6'd1,  8'd1, 64'h0},
    '{3'b000, 6'd2,  8'd2, 64'h0},
    '{3'b001, 6'd1,  8'd0, 64'h0},
    '{3'b001, 6'd2,  8'd0, 64'h0},
    '{3'b000, 6'd1,  8'd3, 64'hF0F0_F0F0_F0F0_F0F0},
    '{3'b001, 6'd1,  8'd0, 64'h0},
    '{3'b000, 6'd63, 8'd4, 64'h0},
    '{3'b001, 6'd63, 8'd0, 64'h0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_en = 1'b0;
  logic [2:0] cmd_op = 3'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic cmd_rdy;
  logic [DW-1:0] wd_data = '0;
  logic [MW-1:0] wd_mask = '0;
  logic wd_end = 1'b0;
  logic wd_en = 1'b0;
  logic wd_rdy;
  logic [DW-1:0] rd_data;
  logic rd_valid, rd_end, calib_done;

  always #2.5 clk = ~clk;

  memui_responder u_dut (
    .clk(clk), .rst(rst),
    .cmd_en(cmd_en), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_rdy(cmd_rdy),
    .wd_data(wd_data), .wd_mask(wd_mask), .wd_end(wd_end), .wd_en(wd_en), .wd_rdy(wd_rdy),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_end(rd_end), .calib_done(calib_done)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int n_ret = 0;
  bit started = 1'b0;

  logic [DW-1:0] model [WORDS];
  logic [DW-1:0] q_d [$];
  logic [MW-1:0] q_m [$];
  int            q_pend [$];
  int            exp_due [$];
  logic [DW-1:0] exp_dat [$];

  always @(posedge clk) cyc = cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int s);
    logic [DW-1:0] r;
    for (int k = 0; k < DW/32; k++) r[k*32 +: 32] = 32'(s) * 32'h9E37_79B1 + 32'(k);
    return r;
  endfunction

  function automatic void model_write(input int idx, input logic [DW-1:0] d, input logic [MW-1:0] m);
    for (int b = 0; b < MW; b++) if (!m[b]) model[idx][b*8 +: 8] = d[b*8 +: 8];
  endfunction

  // R8: word index is address bits [8:3]
  function automatic int widx(input logic [AW-1:0] a);
    return int'(a[8:3]);
  endfunction

  function automatic void apply(input logic [2:0] op, input logic [AW-1:0] a, input int due);
    if (op == 3'b000) begin
      if (q_d.size() > 0) model_write(widx(a), q_d.pop_front(), q_m.pop_front());
      else q_pend.push_back(widx(a));
    end else if (op == 3'b001) begin
      exp_due.push_back(due);
      exp_dat.push_back(model[widx(a)]);
    end
  endfunction

  task automatic push_beat(input logic [DW-1:0] d, input logic [MW-1:0] m);
    wd_data = d; wd_mask = m; wd_en = 1'b1; wd_end = 1'b1;
    while (!wd_rdy) @(negedge clk);
    @(negedge clk);
    wd_en = 1'b0; wd_end = 1'b0;
    if (q_pend.size() > 0) model_write(q_pend.pop_front(), d, m);
    else begin q_d.push_back(d); q_m.push_back(m); end
  endtask

  // R1: the accepting edge is the first edge with cmd_rdy seen high
  task automatic send_cmd(input logic [2:0] op, input logic [AW-1:0] a);
    cmd_op = op; cmd_addr = a; cmd_en = 1'b1;
    while (!cmd_rdy) @(negedge clk);
    apply(op, a, cyc + 5);
    @(negedge clk);
    cmd_en = 1'b0;
  endtask

  task automatic drain();
    while (exp_due.size() > 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // R9 return monitor: valid and end due exactly four edges after acceptance
  always @(negedge clk) begin
    if (started) begin
      if (exp_due.size() > 0 && exp_due[0] == cyc) begin
        check(rd_valid && rd_end, "R9 valid/end on due cycle", DW'({rd_valid, rd_end}), DW'(2'b11));
        check(rd_data == exp_dat[0], "R9 read data", rd_data, exp_dat[0]);
        void'(exp_due.pop_front());
        void'(exp_dat.pop_front());
        n_ret++;
      end else if (rd_valid || rd_end) begin
        check(1'b0, "R9/R3 unexpected return", DW'({rd_valid, rd_end}), DW'(0));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int ret0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!cmd_rdy && !wd_rdy && !rd_valid && !rd_end && !calib_done, "R11 reset outputs",
          DW'({cmd_rdy, wd_rdy, rd_valid, rd_end, calib_done}), DW'(0));
    rst = 1'b0;
    // R10 calibration delay and closed channels
    for (int i = 1; i < 32; i++) begin
      @(negedge clk);
      check(!calib_done && !cmd_rdy && !wd_rdy, "R10 closed before calibration",
            DW'({calib_done, cmd_rdy, wd_rdy}), DW'(0));
    end
    @(negedge clk);
    check(calib_done, "R10 calib_done after 32 edges", DW'(calib_done), DW'(1));
    started = 1'b1;

    // vector table: writes, reads, masked write (R7), top word (R8)
    for (int i = 0; i < 8; i++) begin
      if (TBL[i].op == 3'b000) push_beat(pat(int'(TBL[i].seed)), TBL[i].mask);
      send_cmd(TBL[i].op, AW'(TBL[i].idx) << 3);
    end
    drain();

    // R8: low bits and high bits of the address are ignored
    send_cmd(3'b001, (AW'(1) << 3) | AW'(5));
    send_cmd(3'b001, (AW'(1) << 27) | (AW'(2) << 3) | AW'(7));
    drain();

    // R4 R5: early data fills the FIFO, commands come later
    for (int i = 0; i < 16; i++) push_beat(pat(100 + i), '0);
    for (int i = 0; i < 8; i++) begin
      check(!wd_rdy, "R5 wd_rdy low with 16 queued", DW'(wd_rdy), DW'(0));
      @(negedge clk);
    end
    for (int i = 0; i < 16; i++) send_cmd(3'b000, AW'(10 + i) << 3);
    for (int i = 0; i < 16; i++) send_cmd(3'b001, AW'(10 + i) << 3);
    drain();

    // R2 R1: enable held high, one read per ready edge
    ret0 = n_ret;
    cmd_en = 1'b1;
    cmd_op = 3'b001;
    for (int k = 0; k < 6; ) begin
      cmd_addr = AW'(10 + k) << 3;
      if (cmd_rdy) begin
        apply(3'b001, cmd_addr, cyc + 5);
        k++;
      end
      @(negedge clk);
    end
    cmd_en = 1'b0;
    drain();
    check(n_ret - ret0 == 6, "R2 six back-to-back reads returned", DW'(n_ret - ret0), DW'(6));

    // R6: write without data parks and blocks commands
    send_cmd(3'b000, AW'(20) << 3);
    for (int i = 0; i < 5; i++) begin
      check(!cmd_rdy, "R6 cmd_rdy low while write parked", DW'(cmd_rdy), DW'(0));
      @(negedge clk);
    end
    fork
      send_cmd(3'b001, AW'(20) << 3);
      begin
        repeat (3) @(negedge clk);
        push_beat(pat(200), '0);
      end
    join
    drain();

    // R3: unknown op codes take nothing and return nothing
    push_beat(pat(300), '0);
    ret0 = n_ret;
    send_cmd(3'b010, AW'(1) << 3);
    send_cmd(3'b111, AW'(2) << 3);
    repeat (10) @(negedge clk);
    check(n_ret == ret0, "R3 no return for unknown op", DW'(n_ret - ret0), DW'(0));
    send_cmd(3'b000, AW'(21) << 3);
    send_cmd(3'b001, AW'(21) << 3);
    send_cmd(3'b001, AW'(1) << 3);
    send_cmd(3'b001, AW'(2) << 3);
    drain();
    check(exp_due.size() == 0, "R9 all reads returned", DW'(exp_due.size()), DW'(0));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule